// File: doc/BRIEF.md
# Debug Trace Capture Buffer

This block is the capture memory behind an on-chip debug unit. While a session is armed, a capture port writes one 20-bit trace line per strobe into a 64-line circular store. Once the session has ended, a register bus reads the lines back through a 16-bit window, two accesses per line. A count output gives the number of lines captured since arming. A full flag shows that the count has wrapped, which means every line holds valid data.

Reading is tightly gated. Arming locks the store. After disarming, only an aligned 16-bit write to the readout register unlocks it, and that write places the read pointer at the oldest valid line. Byte or misaligned accesses, reads while armed and reads with the trace-source enable low all return zero and leave the pointer where it is. Power-on reset clears the count and the flag. A system reset leaves the count, the flag and the stored lines intact, so a session that was cut short by a reset can still be inspected afterwards.

Top module: `dbg_trace_buf`

## Requirements
- R1: The store holds 64 lines of 20 bits. While `armIn` is high, each `capStb` writes `capData` at the write position and advances it modulo 64, so after a wrap the oldest line is overwritten.
- R2: A valid read first returns the line's bits 19:16 zero-extended to 16 bits, then returns bits 15:0 on the next valid read, and then moves to the next line. Read data appears on `rdData` in the cycle after the access and is 0 when no valid read took place.
- R3: A rising edge on `armIn` clears the line count, the full flag and the write position, and locks the store. A `capStb` in that same cycle is ignored.
- R4: The store is unlocked only by a write with `busWord`=1 and `busAddr0`=0 while `armIn` is low. Byte writes (`busWord`=0) and misaligned writes (`busAddr0`=1) do not unlock it, and the unlock write leaves the stored lines unchanged.
- R5: A read returns 0 and does not advance the read position when any of these holds: `busWord`=0, `busAddr0`=1, `armIn`=1, `srcEn`=0, or the store is locked.
- R6: `lineCount` equals the number of accepted captures since arming, modulo 64. Reads never decrement it.
- R7: When `lineCount` wraps from 63 to 0, `bufFull` is set. It stays set until the next arming, and counting continues.
- R8: `porRstN` low clears `lineCount`, `bufFull` and the write position, and locks the store. `sysRstN` low leaves the count, the flag, the write position and the contents unchanged, clears `rdData` and locks the store.
- R9: After an unlock, reading starts at line 0 if `bufFull` is clear. If `bufFull` is set, it starts at the line at the write position, which is the oldest line.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| porRstN | input | 1 | Power-on reset, asynchronous, active low |
| sysRstN | input | 1 | System reset, synchronous, active low |
| armIn | input | 1 | Session armed level |
| srcEn | input | 1 | Trace-source enable; reads return zero while low |
| capStb | input | 1 | Capture strobe, one line per cycle |
| capData | input | 20 | Trace line to capture |
| busRd | input | 1 | Read strobe for the readout register |
| busWr | input | 1 | Write strobe for the readout register (unlock) |
| busWord | input | 1 | 1 = 16-bit access, 0 = byte access |
| busAddr0 | input | 1 | Address bit 0; 1 = misaligned |
| rdData | output | 16 | Registered read data |
| lineCount | output | 6 | Lines captured since arming, modulo 64 |
| bufFull | output | 1 | Count has wrapped; all 64 lines are valid |

## Verification
Readout is exercised with a walk of access patterns that mixes aligned word reads with byte reads, misaligned reads and reads with the source enable low. This shows whether each kind of rejected access leaves the two-beat upper/lower sequence and the line pointer untouched. A short session of five lines shows that readout starts at line 0 when the store is not full. A session of 66 captures, begun with a strobe in the arming cycle, shows three things: that the arming-cycle strobe is dropped, that the full flag is sticky while the count keeps running, and that readout begins at the oldest line and follows the overwrite order around the whole store. A system reset in mid-readout is checked to keep the count while relocking the store. A final power-on reset is checked to clear the count and the flag.

// File: rtl/trace_pkg.sv
package trace_pkg;

  // Strobes from the control module into the datapath, one cycle each.
  typedef struct packed {
    logic armClr;   // arming edge: clear count, flag, write position
    logic capWr;    // store capData at the write position
    logic unlock;   // place read pointer at oldest valid line
    logic rdValid;  // accepted readout access
  } ctrlStb_t;

endpackage

// File: rtl/trace_ctrl.sv
module trace_ctrl
  import trace_pkg::*;
(
  input  logic     clk,
  input  logic     porRstN,
  input  logic     sysRstN,
  input  logic     armIn,
  input  logic     srcEn,
  input  logic     capStb,
  input  logic     busRd,
  input  logic     busWr,
  input  logic     busWord,
  input  logic     busAddr0,
  output ctrlStb_t stb
);

  logic armPrev;
  logic locked;
  logic armRise;
  logic alignedWord;
  logic unlockHit;
  logic readOk;

  // Edge detector and lock flag. Only power-on reset forgets the previous
  // arm level, so a system reset during an armed session is not taken
  // as a fresh arming.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      armPrev <= 1'b0;
      locked  <= 1'b1;
    end else if (!sysRstN) begin
      locked  <= 1'b1;
    end else begin
      armPrev <= armIn;
      if (armRise)        locked <= 1'b1;
      else if (unlockHit) locked <= 1'b0;
    end
  end

  always_comb begin
    armRise     = sysRstN & armIn & ~armPrev;
    alignedWord = busWord & ~busAddr0;
    unlockHit   = sysRstN & busWr & alignedWord & ~armIn;
    readOk      = sysRstN & busRd & alignedWord & ~armIn & srcEn & ~locked;

    stb.armClr  = armRise;
    stb.capWr   = sysRstN & armIn & capStb & ~armRise;
    stb.unlock  = unlockHit;
    stb.rdValid = readOk;
  end

  // R8: a system reset always leaves the store locked.
  a_r8_sys_locks: assert property (@(posedge clk) disable iff (!porRstN)
    !sysRstN |=> locked);

  // R3: arming locks the store before any read can get through.
  a_r3_arm_locks: assert property (@(posedge clk) disable iff (!porRstN)
    stb.armClr |=> (locked && !stb.rdValid));

  // R4: an unlock only ever follows a disarmed cycle.
  a_r4_unlock_disarmed: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    stb.unlock |=> !locked || armRise);

endmodule

// File: rtl/trace_dp.sv
module trace_dp
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 20,
  parameter int BUS_W = 16
) (
  input  logic                     clk,
  input  logic                     porRstN,
  input  logic                     sysRstN,
  input  ctrlStb_t                 stb,
  input  logic [WIDTH-1:0]         capData,
  output logic [BUS_W-1:0]         rdData,
  output logic [$clog2(DEPTH)-1:0] lineCount,
  output logic                     bufFull
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int HI_W  = WIDTH - BUS_W;
  localparam int PAD_W = BUS_W - HI_W;

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PTR_W-1:0] cnt;      // count and write position share one register
  logic             full;
  logic [PTR_W-1:0] rdPtr;
  logic             hiNext;   // next accepted read returns the upper part
  logic [WIDTH-1:0] curLine;
  logic [BUS_W-1:0] upperWord;
  logic [BUS_W-1:0] lowerWord;

  // Trace storage: no reset, contents survive every reset.
  always_ff @(posedge clk) begin
    if (stb.capWr) mem[cnt] <= capData;
  end

  // Count / write position and full flag: power-on reset or arming only.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (stb.armClr) begin
      cnt  <= '0;
      full <= 1'b0;
    end else if (stb.capWr) begin
      cnt <= cnt + 1'b1;
      if (cnt == {PTR_W{1'b1}}) full <= 1'b1;
    end
  end

  always_comb begin
    curLine   = mem[rdPtr];
    upperWord = {{PAD_W{1'b0}}, curLine[WIDTH-1:BUS_W]};
    lowerWord = curLine[BUS_W-1:0];
  end

  // Readout side: two beats per line, registered data.
  always_ff @(posedge clk or negedge porRstN) begin
    if (!porRstN) begin
      rdPtr  <= '0;
      hiNext <= 1'b1;
      rdData <= '0;
    end else if (!sysRstN) begin
      rdData <= '0;
    end else begin
      if (stb.rdValid) begin
        rdData <= hiNext ? upperWord : lowerWord;
        hiNext <= ~hiNext;
        if (!hiNext) rdPtr <= rdPtr + 1'b1;
      end else begin
        rdData <= '0;
      end
      if (stb.unlock) begin
        rdPtr  <= full ? cnt : '0;
        hiNext <= 1'b1;
      end
    end
  end

  assign lineCount = cnt;
  assign bufFull   = full;

  // R3: arming leaves an empty, non-full store.
  a_r3_arm_clears: assert property (@(posedge clk) disable iff (!porRstN)
    stb.armClr |=> (cnt == '0 && !full));

  // R7: the full flag only falls through arming.
  a_r7_full_sticky: assert property (@(posedge clk) disable iff (!porRstN)
    (full && !stb.armClr) |=> full);

  // R7: a wrap of the count raises the flag.
  a_r7_wrap_sets_full: assert property (@(posedge clk) disable iff (!porRstN)
    (cnt == {PTR_W{1'b1}} && stb.capWr && !stb.armClr) |=> (full && cnt == '0));

  // R6, R8: without capture or arming the count holds, also through system reset.
  a_r6_count_hold: assert property (@(posedge clk) disable iff (!porRstN)
    (!stb.armClr && !stb.capWr) |=> $stable(cnt));

  // R2: the line pointer steps once per completed line.
  a_r2_ptr_step: assert property (@(posedge clk) disable iff (!porRstN || !sysRstN)
    (stb.rdValid && !hiNext && !stb.unlock) |=> rdPtr == $past(rdPtr) + 1'b1);

  // R5: a rejected access yields zero data.
  a_r5_idle_zero: assert property (@(posedge clk) disable iff (!porRstN)
    !stb.rdValid |=> rdData == '0);

endmodule

// File: rtl/dbg_trace_buf.sv
module dbg_trace_buf
  import trace_pkg::*;
#(
  parameter int DEPTH = 64,
  parameter int WIDTH = 20,
  parameter int BUS_W = 16
) (
  input  logic                     clk,
  input  logic                     porRstN,
  input  logic                     sysRstN,
  input  logic                     armIn,
  input  logic                     srcEn,
  input  logic                     capStb,
  input  logic [WIDTH-1:0]         capData,
  input  logic                     busRd,
  input  logic                     busWr,
  input  logic                     busWord,
  input  logic                     busAddr0,
  output logic [BUS_W-1:0]         rdData,
  output logic [$clog2(DEPTH)-1:0] lineCount,
  output logic                     bufFull
);

  ctrlStb_t stb;

  trace_ctrl u_ctrl (
    .clk      (clk),
    .porRstN  (porRstN),
    .sysRstN  (sysRstN),
    .armIn    (armIn),
    .srcEn    (srcEn),
    .capStb   (capStb),
    .busRd    (busRd),
    .busWr    (busWr),
    .busWord  (busWord),
    .busAddr0 (busAddr0),
    .stb      (stb)
  );

  trace_dp #(
    .DEPTH (DEPTH),
    .WIDTH (WIDTH),
    .BUS_W (BUS_W)
  ) u_dp (
    .clk       (clk),
    .porRstN   (porRstN),
    .sysRstN   (sysRstN),
    .stb       (stb),
    .capData   (capData),
    .rdData    (rdData),
    .lineCount (lineCount),
    .bufFull   (bufFull)
  );

endmodule

// File: tb/dbg_trace_buf_tb.sv
module dbg_trace_buf_tb;

  logic        clk = 1'b0;
  logic        porRstN = 1'b0;
  logic        sysRstN = 1'b1;
  logic        armIn = 1'b0;
  logic        srcEn = 1'b1;
  logic        capStb = 1'b0;
  logic [19:0] capData = '0;
  logic        busRd = 1'b0;
  logic        busWr = 1'b0;
  logic        busWord = 1'b0;
  logic        busAddr0 = 1'b0;
  logic [15:0] rdData;
  logic [5:0]  lineCount;
  logic        bufFull;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #10 clk = ~clk;   // 50 MHz

  dbg_trace_buf u_dut (
    .clk(clk), .porRstN(porRstN), .sysRstN(sysRstN), .armIn(armIn),
    .srcEn(srcEn), .capStb(capStb), .capData(capData), .busRd(busRd),
    .busWr(busWr), .busWord(busWord), .busAddr0(busAddr0),
    .rdData(rdData), .lineCount(lineCount), .bufFull(bufFull)
  );

  // Access table: {busWord, busAddr0, srcEn, expect accepted}
  localparam logic [3:0] ACC_TAB [10] = '{
    4'b1011, 4'b0010, 4'b1110, 4'b1000, 4'b1011,
    4'b0110, 4'b0000, 4'b1011, 4'b1100, 4'b1011
  };

  function automatic logic [19:0] sessA(int i);
    return {4'(i + 9), 16'(i * 16'h1357 + 16'h00A5)};
  endfunction

  function automatic logic [19:0] sessB(int j);
    return {4'(j), 16'((j * 16'h0101) ^ 16'h5A5A)};
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic capture(logic [19:0] d);
    @(negedge clk); capStb = 1'b1; capData = d;
    @(negedge clk); capStb = 1'b0;
  endtask

  // One bus access; returns on the next falling edge, where rdData holds the result.
  task automatic access(logic rd, logic wr, logic word, logic a0);
    @(negedge clk); busRd = rd; busWr = wr; busWord = word; busAddr0 = a0;
    @(negedge clk); busRd = 1'b0; busWr = 1'b0; busWord = 1'b0; busAddr0 = 1'b0;
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      summary();
    end
  end

  initial begin
    int expLine;
    bit expHi;
    logic [15:0] expWord;

    // Power-on reset state
    repeat (3) @(negedge clk);
    porRstN = 1'b1;
    @(negedge clk);
    chk("R8 por count", 32'(lineCount), 0);
    chk("R8 por full", 32'(bufFull), 0);
    chk("R8 por rdData", 32'(rdData), 0);

    // Session A: five lines
    @(negedge clk); armIn = 1'b1;
    for (int i = 0; i < 5; i++) capture(sessA(i));
    chk("R6 count after 5", 32'(lineCount), 5);
    chk("R7 not full", 32'(bufFull), 0);
    access(1, 0, 1, 0);
    chk("R5 read while armed", 32'(rdData), 0);
    @(negedge clk); armIn = 1'b0;
    access(1, 0, 1, 0);
    chk("R5 read while locked", 32'(rdData), 0);
    access(0, 1, 0, 0);
    access(1, 0, 1, 0);
    chk("R4 byte write no unlock", 32'(rdData), 0);
    access(0, 1, 1, 1);
    access(1, 0, 1, 0);
    chk("R4 misaligned write no unlock", 32'(rdData), 0);
    access(0, 1, 1, 0);   // unlock

    // Table walk over access kinds (R2, R5, R9 start at line 0)
    expLine = 0; expHi = 1'b1;
    for (int k = 0; k < 10; k++) begin
      srcEn = ACC_TAB[k][1];
      access(1, 0, ACC_TAB[k][3], ACC_TAB[k][2]);
      if (ACC_TAB[k][0]) begin
        expWord = expHi ? {12'h000, sessA(expLine)[19:16]} : sessA(expLine)[15:0];
        if (!expHi) expLine++;
        expHi = ~expHi;
      end else begin
        expWord = '0;
      end
      chk($sformatf("R2 R5 table entry %0d", k), 32'(rdData), 32'(expWord));
    end
    srcEn = 1'b1;
    @(negedge clk);
    chk("R2 idle rdData zero", 32'(rdData), 0);
    chk("R6 count kept after reads", 32'(lineCount), 5);

    // System reset mid-readout
    @(negedge clk); sysRstN = 1'b0;
    @(negedge clk); sysRstN = 1'b1;
    chk("R8 sys keeps count", 32'(lineCount), 5);
    chk("R8 sys keeps full", 32'(bufFull), 0);
    access(1, 0, 1, 0);
    chk("R8 sys relocks", 32'(rdData), 0);
    access(0, 1, 1, 0);
    access(1, 0, 1, 0);
    chk("R9 restart line 0 upper", 32'(rdData), 32'({12'h000, sessA(0)[19:16]}));
    access(1, 0, 1, 0);
    chk("R4 contents kept lower", 32'(rdData), 32'(sessA(0)[15:0]));

    // Session B: strobe in arming cycle, then 66 lines
    @(negedge clk); armIn = 1'b1; capStb = 1'b1; capData = 20'hFFFFF;
    @(negedge clk); capStb = 1'b0;
    chk("R3 arm clears count", 32'(lineCount), 0);
    chk("R3 arm clears full", 32'(bufFull), 0);
    for (int j = 0; j < 63; j++) capture(sessB(j));
    chk("R7 count 63 not full", 32'(bufFull), 0);
    capture(sessB(63));
    chk("R7 wrap sets full", 32'(bufFull), 1);
    chk("R7 wrap count zero", 32'(lineCount), 0);
    capture(sessB(64));
    capture(sessB(65));
    chk("R3 R6 count after 66", 32'(lineCount), 2);
    chk("R7 full sticky", 32'(bufFull), 1);
    @(negedge clk); armIn = 1'b0;
    access(0, 1, 1, 0);
    for (int n = 0; n < 64; n++) begin
      access(1, 0, 1, 0);
      chk($sformatf("R1 R9 line %0d upper", n), 32'(rdData),
          32'({12'h000, sessB(n + 2)[19:16]}));
      access(1, 0, 1, 0);
      chk($sformatf("R1 R2 line %0d lower", n), 32'(rdData), 32'(sessB(n + 2)[15:0]));
    end

    // Final power-on reset
    @(negedge clk); porRstN = 1'b0;
    @(negedge clk); porRstN = 1'b1;
    chk("R8 por clears count", 32'(lineCount), 0);
    chk("R8 por clears full", 32'(bufFull), 0);

    done = 1;
    summary();
  end

endmodule